// File: doc/BRIEF.md
# Sequential unsigned multiply/divide unit

This unit carries out the two long arithmetic commands of an 8-bit accumulator CPU over many clocks. The multiply command forms the 16-bit unsigned product of the accumulator byte and the X byte. The divide command splits the 16-bit AX value by the 8-bit C value. The whole quotient goes back to AX and the remainder goes back to C.

The CPU raises `start` for one clock, with the command on `op_div` and the current register values on the operand inputs. The unit then runs for a fixed number of clocks: 32 for multiply and 50 for divide. It shows the finished values on `ax_out` and `c_out` and marks them with a one-clock `done` strobe. The CPU writes the values back itself. Fetch, decode, the register file and the status flags belong to the CPU, and this unit never touches the flags.

Top module: `muldiv_seq`

## Requirements
- R1: With `op_div` = 0, the unit finishes with `ax_out` = `a_in` × `x_in`, treated as unsigned 16-bit. It also sets `c_out` to the `c_in` value captured at start, so the C register is written back unchanged.
- R2: With `op_div` = 1 and `c_in` ≠ 0, the unit finishes with `ax_out` = floor(`ax_in` / `c_in`) as a full 16-bit quotient and `c_out` = `ax_in` mod `c_in`.
- R3: With `op_div` = 1 and `c_in` = 0, the unit finishes with `ax_out` = 16'hFFFF and `c_out` = `ax_in[7:0]`, and still uses the full divide latency.
- R4: For a multiply accepted at rising edge k, `done` is high in exactly the clock that follows edge k+32.
- R5: For a divide accepted at rising edge k, `done` is high in exactly the clock that follows edge k+50.
- R6: `busy` is high from the edge after acceptance until the edge at which `done` rises. `done` lasts one clock and is never high together with `busy`.
- R7: A `start` seen while `busy` is high is ignored. The command that is running keeps its operands, its results and its latency.
- R8: `ax_out` and `c_out` change only at the edge where `done` rises. They hold from one `done` to the next, whatever the inputs do.
- R9: While `rst` is high at a rising edge, the following clock shows `busy` = 0, `done` = 0, `ax_out` = 0 and `c_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-clock command request, accepted only when idle |
| op_div | input | 1 | Command select: 0 multiply, 1 divide |
| a_in | input | 8 | Accumulator byte (multiplicand) |
| x_in | input | 8 | X byte (multiplier) |
| ax_in | input | 16 | AX pair (dividend) |
| c_in | input | 8 | C byte (divisor; returned unchanged by multiply) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock strobe: results are valid |
| ax_out | output | 16 | Product or quotient |
| c_out | output | 8 | Remainder, or C unchanged after multiply |

## Verification
On every cycle the assertions check four things: `done` comes exactly 32 or 50 edges after acceptance, `done` never overlaps `busy`, outputs stay stable between strobes, and each strobe carries the product, quotient, remainder or divide-by-zero pattern for the captured operands. Some behaviour only the bench scenarios can show. One case is a `start` landing on the very edge `done` rises, or one clock later. Other cases are repeated pulses during a running command, back-to-back commands of mixed type, and edge operands such as 255 × 255, 65535 / 1 and a dividend smaller than the divisor. The bench also shows reset in the middle of a command.

// File: rtl/muldiv_seq.sv
module muldiv_seq #(
  parameter int DW = 8,
  parameter int MUL_CYCLES = 32,
  parameter int DIV_CYCLES = 50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op_div,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] x_in,
  input  logic [2*DW-1:0] ax_in,
  input  logic [DW-1:0] c_in,
  output logic          busy,
  output logic          done,
  output logic [2*DW-1:0] ax_out,
  output logic [DW-1:0] c_out
);
  localparam int PW = 2 * DW;
  localparam int CW = $clog2(DIV_CYCLES);
  localparam logic [CW-1:0] MUL_LAST = CW'(MUL_CYCLES - 1);
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV_CYCLES - 1);
  localparam logic [CW-1:0] MUL_STEPS = CW'(DW);
  localparam logic [CW-1:0] DIV_STEPS = CW'(PW);

  logic          op_q;
  logic [CW-1:0] cnt;
  logic [DW-1:0] mcand, mplier, dvsr, c_keep;
  logic [PW-1:0] acc;
  logic [DW:0]   prem;

  logic [DW:0]   trial, diff;
  logic          fits, last, mul_step, div_step;
  logic [PW-1:0] addend;

  assign trial    = {prem[DW-1:0], acc[PW-1]};
  assign fits     = trial >= {1'b0, dvsr};
  assign diff     = trial - {1'b0, dvsr};
  assign last     = cnt == (op_q ? DIV_LAST : MUL_LAST);
  assign mul_step = busy && !op_q && cnt < MUL_STEPS;
  assign div_step = busy && op_q && cnt < DIV_STEPS;
  assign addend   = mplier[0] ? ({{DW{1'b0}}, mcand} << cnt) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      op_q   <= 1'b0;
      mcand  <= '0;
      mplier <= '0;
      dvsr   <= '0;
      c_keep <= '0;
      acc    <= '0;
      prem   <= '0;
      ax_out <= '0;
      c_out  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          cnt    <= '0;
          op_q   <= op_div;
          mcand  <= a_in;
          mplier <= x_in;
          dvsr   <= c_in;
          c_keep <= c_in;
          acc    <= op_div ? ax_in : '0;
          prem   <= '0;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (mul_step) begin
          acc    <= acc + addend;
          mplier <= mplier >> 1;
        end
        if (div_step) begin
          acc  <= {acc[PW-2:0], fits};
          prem <= fits ? diff : trial;
        end
        if (last) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          ax_out <= acc;
          c_out  <= op_q ? prem[DW-1:0] : c_keep;
        end
      end
    end
  end
endmodule

// File: rtl/muldiv_seq_chk.sv
module muldiv_seq_chk #(
  parameter int DW = 8,
  parameter int MUL_CYCLES = 32,
  parameter int DIV_CYCLES = 50
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          op_div,
  input logic [DW-1:0] a_in,
  input logic [DW-1:0] x_in,
  input logic [2*DW-1:0] ax_in,
  input logic [DW-1:0] c_in,
  input logic          busy,
  input logic          done,
  input logic [2*DW-1:0] ax_out,
  input logic [DW-1:0] c_out
);
  logic            run, ccmd;
  logic [7:0]      n;
  logic [DW-1:0]   ca, cx, cc;
  logic [2*DW-1:0] cax;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      n   <= '0;
      ccmd <= 1'b0;
      ca <= '0; cx <= '0; cc <= '0; cax <= '0;
    end else if (!busy && start) begin
      run <= 1'b1;
      n   <= '0;
      ccmd <= op_div;
      ca <= a_in; cx <= x_in; cc <= c_in; cax <= ax_in;
    end else if (done) begin
      run <= 1'b0;
    end else if (run) begin
      n <= n + 1'b1;
    end
  end

  // R4
  mul_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done && !ccmd |-> run && n == 8'(MUL_CYCLES));
  // R5
  div_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done && ccmd |-> run && n == 8'(DIV_CYCLES));
  // R1
  mul_result_chk: assert property (@(posedge clk) disable iff (rst)
    done && !ccmd |-> ax_out == 16'(ca * cx) && c_out == cc);
  // R2
  div_result_chk: assert property (@(posedge clk) disable iff (rst)
    done && ccmd && cc != 0 |-> ax_out == cax / 16'(cc) && c_out == DW'(cax % 16'(cc)));
  // R3
  div_zero_chk: assert property (@(posedge clk) disable iff (rst)
    done && ccmd && cc == 0 |-> ax_out == '1 && c_out == cax[DW-1:0]);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));
  // R7
  ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> busy || done);
  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(ax_out) && $stable(c_out));
  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> !busy && !done && ax_out == '0 && c_out == '0);
endmodule

bind muldiv_seq muldiv_seq_chk #(.DW(DW), .MUL_CYCLES(MUL_CYCLES), .DIV_CYCLES(DIV_CYCLES)) u_chk (.*);

// File: tb/muldiv_seq_test.sv
module muldiv_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, start = 0, op_div = 0;
  logic [7:0] a_in = 0, x_in = 0, c_in = 0;
  logic [15:0] ax_in = 0;
  logic busy, done;
  logic [15:0] ax_out;
  logic [7:0] c_out;

  muldiv_seq uut (.clk(clk), .rst(rst), .start(start), .op_div(op_div),
    .a_in(a_in), .x_in(x_in), .ax_in(ax_in), .c_in(c_in),
    .busy(busy), .done(done), .ax_out(ax_out), .c_out(c_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, errors = 0, cycles = 0;
  bit reported = 0;
  string tag = "R9";

  bit m_busy = 0, m_done = 0, m_cmd = 0;
  int m_count = 0;
  int m_a, m_x, m_ax, m_c;
  int e_ax = 0, e_c = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_busy = 0; m_done = 0; m_count = 0; e_ax = 0; e_c = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_count++;
        if (m_count == (m_cmd ? 50 : 32)) begin
          m_busy = 0; m_done = 1;
          if (!m_cmd) begin e_ax = (m_a * m_x) % 65536; e_c = m_c; end
          else if (m_c == 0) begin e_ax = 65535; e_c = m_ax % 256; end
          else begin e_ax = m_ax / m_c; e_c = m_ax % m_c; end
        end
      end else if (start) begin
        m_busy = 1; m_count = 0; m_cmd = op_div;
        m_a = a_in; m_x = x_in; m_ax = ax_in; m_c = c_in;
      end
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (busy !== m_busy || done !== m_done || ax_out !== 16'(e_ax) || c_out !== 8'(e_c)) begin
      errors++;
      $display("FAIL %s t=%0t busy/done/ax/c actual %b/%b/%h/%h expected %b/%b/%h/%h",
        tag, $time, busy, done, ax_out, c_out, m_busy, m_done, 16'(e_ax), 8'(e_c));
    end
  end

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  always @(posedge clk) if (cycles > 150000) begin
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic issue(bit d, logic [7:0] a, logic [7:0] x, logic [15:0] ax, logic [7:0] c);
    op_div = d; a_in = a; x_in = x; ax_in = ax; c_in = c; start = 1;
    tick(1);
    start = 0;
  endtask

  task automatic run(bit d, logic [7:0] a, logic [7:0] x, logic [15:0] ax, logic [7:0] c);
    issue(d, a, x, ax, c);
    tick(d ? 51 : 33);
  endtask

  initial begin
    tag = "R9"; tick(3); rst = 0; tick(2);
    tag = "R1"; run(0, 8'd13, 8'd11, 16'h1234, 8'h5A); run(0, 8'hFF, 8'hFF, 0, 8'h01);
    run(0, 0, 8'h77, 0, 8'h02); run(0, 8'h80, 8'h01, 0, 8'hC3);
    tag = "R4"; for (int i = 0; i < 6; i++) run(0, 8'($urandom), 8'($urandom), 0, 8'($urandom));
    tag = "R2"; run(1, 0, 0, 16'd1000, 8'd7); run(1, 0, 0, 16'hFFFF, 8'd1);
    run(1, 0, 0, 16'd5, 8'd200); run(1, 0, 0, 16'hFFFF, 8'hFF);
    tag = "R5"; for (int i = 0; i < 6; i++) run(1, 0, 0, 16'($urandom), 8'($urandom) | 8'h01);
    tag = "R3"; run(1, 0, 0, 16'hBEEF, 0); run(1, 0, 0, 0, 0);
    tag = "R6"; issue(0, 8'd9, 8'd9, 0, 8'd1); tick(31); issue(1, 0, 0, 16'd900, 8'd30);
    tick(49); issue(0, 8'd3, 8'd4, 0, 8'd5); tick(40);
    tag = "R7"; issue(1, 0, 0, 16'd4321, 8'd10); tick(5); issue(0, 8'hFF, 8'h02, 16'd1, 8'd3);
    tick(20); issue(1, 0, 0, 0, 0); tick(30);
    tag = "R8"; op_div = 1; ax_in = 16'hAAAA; c_in = 0; a_in = 8'h55; tick(20);
    tag = "R9"; issue(1, 0, 0, 16'd777, 8'd3); tick(10); rst = 1; tick(2); rst = 0; tick(5);
    tag = "R1"; run(0, 8'd200, 8'd3, 0, 8'd9);
    report();
  end
endmodule